// File: doc/BRIEF.md
# Triggered Capture Write Controller

This block is the front end of an on-chip signal recorder. Once armed, it takes a probe word and a trigger bit with every valid sample and writes each sample into a circular capture RAM of `DEPTH` entries. The write address starts at zero and wraps. Each incoming trigger bit is tested against a selected condition: a rising edge, a falling edge, a high level or a low level.

When the condition is met, the block works out where the capture window begins in the ring and sends out that address with a one-cycle strobe. A percentage setting splits the ring between history taken before the trigger and samples taken after it. The block writes the agreed number of post-trigger samples and then raises a one-cycle finish pulse. After that it stops. It writes nothing and ignores the trigger until the arm input is dropped and raised again. The register file that owns the arm bit uses the finish pulse to clear that bit.

Top module: `capture_write_ctrl`

## Requirements
- R1: During and directly after reset, `wr_en`, `win_start_vld` and `done_pulse` are 0, and `wr_addr` and `win_start` are 0.
- R2: While capturing, each accepted sample appears on the write port in the next cycle. `wr_en` is 1, `wr_data` holds the sample, and `wr_addr` counts up from 0 after arming and wraps from DEPTH-1 back to 0.
- R3: A cycle with `smp_valid` low writes nothing and advances no address. Its trigger value takes no part in detection.
- R4: `trig_mode` selects the condition, tested only on accepted samples. 0 means rising (previous accepted bit 0, current bit 1). 1 means falling. 2 means level high. 3 means level low. The first sample after arming has no predecessor, so it can never be an edge.
- R5: The pre-trigger share is P = floor((DEPTH*pct + 50)/100). The trigger sample opens the post-trigger part, which holds exactly DEPTH-P written samples, so P = DEPTH writes nothing after the trigger.
- R6: The window start is (A - P) mod DEPTH, where A is the address the trigger sample takes. It is 0 when fewer than P samples were written before the trigger.
- R7: `win_start_vld` is a one-cycle pulse that appears in the cycle the trigger sample would be written, and it occurs once per capture.
- R8: `done_pulse` is a one-cycle pulse. It coincides with the write of the last post-trigger sample, or with `win_start_vld` when DEPTH-P is 0.
- R9: After the trigger, further trigger activity is ignored. After `done_pulse`, no writes and no trigger occur until `arm_en` has been low and is raised again.
- R10: A `pre_pct` value above 100 behaves as 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_en | input | 1 | Arms the capture; must drop low before the block can re-arm |
| trig_mode | input | 2 | Trigger condition: 0 rise, 1 fall, 2 high, 3 low |
| pre_pct | input | 8 | Percentage of the ring kept before the trigger |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Probe word |
| trig_in | input | 1 | Trigger bit |
| wr_en | output | 1 | RAM write enable |
| wr_addr | output | $clog2(DEPTH) | RAM write address |
| wr_data | output | DATA_W | RAM write data |
| win_start | output | $clog2(DEPTH) | First address of the capture window |
| win_start_vld | output | 1 | Strobe for `win_start` |
| done_pulse | output | 1 | Capture finished |

## Verification
The bench drives triggers early enough that the start address must be clamped, and late enough that the pointer has wrapped several times. A design that skipped the clamp would report a window start pointing into unwritten RAM, and one with a wrong modulo would be off by a ring length. It runs the 0 and 100 percent ends and a setting above 100. Off-by-one post counts or a missing clamp show up there as an extra or missing write, or as a finish pulse that lands in the wrong cycle. A trigger bit held high from the first sample, toggling after the trigger, and flipping during invalid cycles exposes a detector that invents an edge, fires a second time, or samples on strobe-less cycles. Samples keep coming after the finish pulse, so a block that did not hold would keep writing.

// File: rtl/wcap_pkg.sv
package wcap_pkg;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_PRE  = 2'd1,
    CS_POST = 2'd2,
    CS_HOLD = 2'd3
  } cap_state_e;

  typedef enum logic [1:0] {
    TM_RISE = 2'd0,
    TM_FALL = 2'd1,
    TM_HIGH = 2'd2,
    TM_LOW  = 2'd3
  } trig_mode_e;

  // Number of ring entries kept ahead of the trigger, rounded half up.
  function automatic int pre_count(input int depth, input int pct);
    int p;
    p = (pct > 100) ? 100 : pct;
    return (depth * p + 50) / 100;
  endfunction

  // First ring address of the window; zero when history is short.
  function automatic int ring_start(input int depth, input int addr,
                                    input int pre, input int fill);
    if (fill < pre) return 0;
    return (addr + depth - pre) % depth;
  endfunction

endpackage

// File: rtl/wcap_trig_detect.sv
module wcap_trig_detect
  import wcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       sample_en,
  input  logic       trig_in,
  input  logic [1:0] mode,
  output logic       hit
);

  logic prev_q;
  logic hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hist_q <= 1'b0;
    end else if (clear) begin
      prev_q <= 1'b0;
      hist_q <= 1'b0;
    end else if (sample_en) begin
      prev_q <= trig_in;
      hist_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (trig_mode_e'(mode))
      TM_RISE: hit = hist_q & ~prev_q &  trig_in;
      TM_FALL: hit = hist_q &  prev_q & ~trig_in;
      TM_HIGH: hit =  trig_in;
      TM_LOW:  hit = ~trig_in;
      default: hit = 1'b0;
    endcase
  end

  // R4
  edge_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !hist_q);

endmodule

// File: rtl/wcap_ring_ptr.sv
module wcap_ring_ptr #(
  parameter  int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  output logic [ADDR_W-1:0] ptr,
  output logic [CNT_W-1:0]  fill
);

  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  FULL_C = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] ptr_q;
  logic [CNT_W-1:0]  fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      fill_q <= '0;
    end else if (clear) begin
      ptr_q  <= '0;
      fill_q <= '0;
    end else if (advance) begin
      ptr_q  <= (ptr_q == LAST_A) ? '0 : ptr_q + 1'b1;
      if (fill_q != FULL_C) fill_q <= fill_q + 1'b1;
    end
  end

  assign ptr  = ptr_q;
  assign fill = fill_q;

  // R2
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clear && ptr_q == LAST_A) |=> ptr_q == '0);

  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FULL_C);

endmodule

// File: rtl/wcap_window_calc.sv
module wcap_window_calc
  import wcap_pkg::*;
#(
  parameter  int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic [7:0]        pct,
  input  logic [ADDR_W-1:0] trig_addr,
  input  logic [CNT_W-1:0]  fill,
  output logic [CNT_W-1:0]  pre_cnt,
  output logic [CNT_W-1:0]  post_cnt,
  output logic [ADDR_W-1:0] start_addr
);

  always_comb begin
    pre_cnt    = CNT_W'(pre_count(DEPTH, int'(pct)));
    post_cnt   = CNT_W'(DEPTH) - pre_cnt;
    start_addr = ADDR_W'(ring_start(DEPTH, int'(trig_addr),
                                    int'(pre_cnt), int'(fill)));
  end

endmodule

// File: rtl/capture_write_ctrl.sv
module capture_write_ctrl
  import wcap_pkg::*;
#(
  parameter  int DATA_W = 8,
  parameter  int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_en,
  input  logic [1:0]        trig_mode,
  input  logic [7:0]        pre_pct,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              trig_in,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] win_start,
  output logic              win_start_vld,
  output logic              done_pulse
);

  cap_state_e        st_q;
  logic [CNT_W-1:0]  post_left_q;

  // Named internal events
  logic              ring_clear;
  logic              accept;
  logic              trig_hit;
  logic              fire;
  logic              do_write;
  logic              done_now;
  logic [ADDR_W-1:0] ring_ptr;
  logic [CNT_W-1:0]  ring_fill;
  logic [CNT_W-1:0]  pre_cnt;
  logic [CNT_W-1:0]  post_cnt;
  logic [ADDR_W-1:0] start_addr;

  assign ring_clear = (st_q == CS_IDLE);
  assign accept     = arm_en && smp_valid && (st_q == CS_PRE || st_q == CS_POST);
  assign fire       = accept && (st_q == CS_PRE) && trig_hit;
  assign do_write   = accept && !(fire && post_cnt == '0);
  assign done_now   = (fire && post_cnt <= CNT_W'(1)) ||
                      (accept && st_q == CS_POST && post_left_q == CNT_W'(1));

  wcap_trig_detect u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (ring_clear),
    .sample_en (accept),
    .trig_in   (trig_in),
    .mode      (trig_mode),
    .hit       (trig_hit)
  );

  wcap_ring_ptr #(.DEPTH(DEPTH)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (ring_clear),
    .advance (do_write),
    .ptr     (ring_ptr),
    .fill    (ring_fill)
  );

  wcap_window_calc #(.DEPTH(DEPTH)) u_window (
    .pct        (pre_pct),
    .trig_addr  (ring_ptr),
    .fill       (ring_fill),
    .pre_cnt    (pre_cnt),
    .post_cnt   (post_cnt),
    .start_addr (start_addr)
  );

  // Capture sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= CS_IDLE;
      post_left_q <= '0;
    end else if (!arm_en) begin
      st_q        <= CS_IDLE;
      post_left_q <= '0;
    end else begin
      unique case (st_q)
        CS_IDLE: st_q <= CS_PRE;
        CS_PRE: begin
          if (fire) begin
            if (done_now) begin
              st_q <= CS_HOLD;
            end else begin
              st_q        <= CS_POST;
              post_left_q <= post_cnt - 1'b1;
            end
          end
        end
        CS_POST: begin
          if (accept) begin
            if (done_now) st_q <= CS_HOLD;
            post_left_q <= post_left_q - 1'b1;
          end
        end
        CS_HOLD: st_q <= CS_HOLD;
        default: st_q <= CS_IDLE;
      endcase
    end
  end

  // Registered RAM write port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= do_write;
      if (do_write) begin
        wr_addr <= ring_ptr;
        wr_data <= smp_data;
      end
    end
  end

  // Window report and finish pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_start     <= '0;
      win_start_vld <= 1'b0;
      done_pulse    <= 1'b0;
    end else begin
      win_start_vld <= fire;
      done_pulse    <= done_now;
      if (fire) win_start <= start_addr;
    end
  end

  // R7
  start_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_start_vld |=> !win_start_vld);

  // R8
  done_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  // R4
  start_from_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_start_vld |-> $past(trig_hit));

  // R9
  fire_only_armed_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_start_vld |-> $past(st_q) == CS_PRE);

  // R9
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == CS_HOLD) |-> !wr_en);

  // R3
  write_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(smp_valid));

endmodule

// File: tb/test_capture_write_ctrl.sv
`timescale 1ns/1ps
module test_capture_write_ctrl;

  localparam int DW = 8;
  localparam int N  = 16;
  localparam int AW = $clog2(N);

  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  pct;
    logic [15:0] ti;
    logic [15:0] exp_start;
    logic        tog;
    logic        gap;
  } vec_t;

  // mode, pct, trigger sample index, expected window start, toggle, gaps
  localparam vec_t VECS [10] = '{
    '{2'd0, 8'd50,  16'd20, 16'd12, 1'b1, 1'b0},
    '{2'd0, 8'd30,  16'd9,  16'd4,  1'b0, 1'b0},
    '{2'd0, 8'd70,  16'd30, 16'd3,  1'b0, 1'b1},
    '{2'd0, 8'd100, 16'd20, 16'd4,  1'b0, 1'b0},
    '{2'd0, 8'd0,   16'd7,  16'd7,  1'b0, 1'b0},
    '{2'd1, 8'd50,  16'd3,  16'd0,  1'b0, 1'b1},
    '{2'd2, 8'd50,  16'd0,  16'd0,  1'b0, 1'b0},
    '{2'd3, 8'd30,  16'd40, 16'd3,  1'b1, 1'b0},
    '{2'd0, 8'd120, 16'd18, 16'd2,  1'b0, 1'b0},
    '{2'd0, 8'd50,  16'd16, 16'd8,  1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_en = 1'b0;
  logic [1:0] trig_mode = 2'd0;
  logic [7:0] pre_pct = 8'd50;
  logic smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic trig_in = 1'b0;
  logic wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [AW-1:0] win_start;
  logic win_start_vld;
  logic done_pulse;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // monitor record
  int m_writes, m_starts, m_dones, m_start_val, m_last_addr, m_last_data;
  int m_start_wr, m_start_data, m_done_wr, m_done_data, m_done_st, m_done_nwr;

  always #10 clk = ~clk;

  capture_write_ctrl #(.DATA_W(DW), .DEPTH(N)) i_capture_write_ctrl (
    .clk(clk), .rst_n(rst_n), .arm_en(arm_en), .trig_mode(trig_mode),
    .pre_pct(pre_pct), .smp_valid(smp_valid), .smp_data(smp_data),
    .trig_in(trig_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .win_start(win_start), .win_start_vld(win_start_vld),
    .done_pulse(done_pulse)
  );

  always @(negedge clk) begin
    if (wr_en) begin
      m_writes++;
      m_last_addr = int'(wr_addr);
      m_last_data = int'(wr_data);
    end
    if (win_start_vld) begin
      m_starts++;
      m_start_val  = int'(win_start);
      m_start_wr   = int'(wr_en);
      m_start_data = int'(wr_data);
    end
    if (done_pulse) begin
      m_dones++;
      m_done_wr   = int'(wr_en);
      m_done_data = int'(wr_data);
      m_done_st   = int'(win_start_vld);
      m_done_nwr  = m_writes;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    m_writes = 0; m_starts = 0; m_dones = 0; m_start_val = -1;
    m_last_addr = -1; m_last_data = -1; m_start_wr = -1; m_start_data = -1;
    m_done_wr = -1; m_done_data = -1; m_done_st = -1; m_done_nwr = -1;
  endtask

  function automatic logic trig_of(input int mode, input int k, input int ti,
                                   input bit tog);
    logic b;
    b = (mode == 0 || mode == 2) ? (k >= ti) : (k < ti);
    if (tog && k > ti) b = ((k - ti) % 2 == 0) ? b : ~b;
    return b;
  endfunction

  task automatic arm(input int mode, input int pct);
    @(negedge clk);
    clear_mon();
    trig_mode = 2'(mode);
    pre_pct   = 8'(pct);
    arm_en    = 1'b1;
    @(negedge clk);
  endtask

  task automatic disarm();
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    arm_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic feed(input int mode, input int ti, input int cnt,
                      input bit tog, input bit gap, input bit force_hi);
    for (int k = 0; k < cnt; k++) begin
      if (gap && (k % 3 == 1)) begin
        smp_valid = 1'b0;
        smp_data  = 8'hEE;
        trig_in   = ~trig_of(mode, k, ti, tog);
        @(negedge clk);
      end
      smp_valid = 1'b1;
      smp_data  = DW'(k);
      trig_in   = force_hi ? 1'b1 : trig_of(mode, k, ti, tog);
      @(negedge clk);
    end
    smp_valid = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 wr_en in reset", int'(wr_en), 0);
    chk("R1 start_vld in reset", int'(win_start_vld), 0);
    chk("R1 done in reset", int'(done_pulse), 0);
    chk("R1 wr_addr in reset", int'(wr_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset outputs", int'({wr_en, win_start_vld, done_pulse}), 0);
    chk("R1 win_start after reset", int'(win_start), 0);

    for (int v = 0; v < 10; v++) begin
      int p, post, mode, ti, exp_wr;
      mode = int'(VECS[v].mode);
      ti   = int'(VECS[v].ti);
      p    = (int'(VECS[v].pct) > 100) ? N : (N * int'(VECS[v].pct) + 50) / 100;
      post = N - p;
      exp_wr = ti + post;
      arm(mode, int'(VECS[v].pct));
      feed(mode, ti, ti + N + 6, VECS[v].tog, VECS[v].gap, 1'b0);
      disarm();
      // R5 R10 post share sizes the number of writes
      chk($sformatf("R5 R10 vec%0d writes", v), m_writes, exp_wr);
      // R6 window start with wrap and clamp
      chk($sformatf("R6 vec%0d start", v), m_start_val, int'(VECS[v].exp_start));
      // R7 R9 exactly one start strobe
      chk($sformatf("R7 R9 vec%0d starts", v), m_starts, 1);
      chk($sformatf("R8 vec%0d dones", v), m_dones, 1);
      // R2 address wraps, data follows samples
      chk($sformatf("R2 vec%0d last addr", v), m_last_addr, (exp_wr - 1) % N);
      chk($sformatf("R2 R3 vec%0d last data", v), m_last_data,
          (post > 0) ? exp_wr - 1 : ti - 1);
      if (post > 0) begin
        chk($sformatf("R7 vec%0d trig sample write", v), m_start_wr, 1);
        chk($sformatf("R7 vec%0d trig sample data", v), m_start_data, ti);
        chk($sformatf("R8 vec%0d done with last write", v), m_done_wr, 1);
        chk($sformatf("R8 vec%0d done write count", v), m_done_nwr, exp_wr);
      end else begin
        chk($sformatf("R5 vec%0d no trig write", v), m_start_wr, 0);
        chk($sformatf("R8 vec%0d done with start", v), m_done_st, 1);
      end
    end

    // R4 a level already high at the first sample is no rising edge;
    // R2 twenty writes wrap the address to 3
    arm(0, 50);
    feed(0, 0, 20, 1'b0, 1'b0, 1'b1);
    disarm();
    chk("R4 no edge without history", m_starts, 0);
    chk("R4 no finish without trigger", m_dones, 0);
    chk("R2 free-run writes", m_writes, 20);
    chk("R2 free-run wrap addr", m_last_addr, 3);
    chk("R2 free-run data", m_last_data, 19);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule